// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Engine

This block moves single bytes over a two-wire synchronous link. One line carries data in both directions, one direction at a time. The other line is a shift clock that the engine always drives. Pulsing the write strobe loads a byte and sends it least-significant bit first. When nothing is being sent, receive-enable is high and the receive-done flag is clear, the engine clocks eight bits in from the data line instead.

The bit period is chosen per frame by a speed input: 12 system clocks normally, or 4 in fast mode. Within each bit, new data goes out a quarter period before the shift clock falls. The clock then stays low for half a period and rises again, and incoming data is captured on that rising edge. The bidirectional pin is modelled as separate input, output and output-enable ports. Transmit-done and receive-done flags stay set until their clear strobes are pulsed, and the received byte is held on its own output register.

Top module: `sync_shift_engine`

## Requirements
- R1: After reset the shift clock is high, the output enable is low, both flags are 0 and the received-byte output is 0x00.
- R2: A transmitted frame is exactly 8 bits. They are presented least-significant first, one per shift-clock rising edge, with the output enable high.
- R3: The speed input, sampled when a frame starts, sets its bit period. Fast mode (1) gives 4 clocks: data leads the falling clock edge by 1 clock and the clock stays low 2 clocks. Slow mode (0) gives 12 clocks, with a 3-clock lead and a 6-clock low time. The data output does not change while the clock is low.
- R4: The transmit-done flag rises on the clock edge that comes 8 bit periods after the edge that accepted the write. The output enable drops on that same edge.
- R5: When idle with receive-enable 1 and the receive-done flag 0, the engine starts a reception. The data input is captured at each of 8 shift-clock rising edges, least-significant first. After the 8th, the receive-done flag is set and the received-byte output takes the new byte.
- R6: No reception starts while the receive-done flag is 1 or receive-enable is 0. The shift clock stays high and the received byte is unchanged.
- R7: A write strobe during a frame is ignored. A write strobe in the same cycle that a reception could start wins, and a transmission begins.
- R8: Each flag stays set until its clear strobe is pulsed. A flag being set and cleared in the same cycle ends up set.
- R9: The output enable is low whenever the engine is idle or receiving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_i | input | 1 | Speed select sampled at frame start (1 = 4-clock bit) |
| tx_wr_i | input | 1 | Write strobe: load byte and transmit |
| tx_byte_i | input | 8 | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| clr_txf_i | input | 1 | Clear strobe for transmit-done flag |
| clr_rxf_i | input | 1 | Clear strobe for receive-done flag |
| sd_i | input | 1 | Data pin input value |
| sd_o | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock, idles high |
| txf_o | output | 1 | Transmit-done flag |
| rxf_o | output | 1 | Receive-done flag |
| rx_byte_o | output | 8 | Last received byte |

## Verification
The hardest case to reach is a set and a clear of the transmit flag landing in the same cycle. The clear strobe must arrive exactly on the edge where the last bit period ends. The stimulus counts bit periods from the accepted write and raises the clear strobe on that edge, then checks that the flag still reads 1. Two other cases need the same counting: a second write placed in the middle of a frame, and a write that coincides with a pending reception start. Both are driven at computed cycles, and the scoreboard would report any extra frame.

// File: rtl/sse_pkg.sv
package sse_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} sse_dir_e;
endpackage

// File: rtl/sse_timing.sv
module sse_timing #(
  parameter int BITS   = 8,
  parameter int SLOW_P = 12,
  parameter int FAST_P = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fast_i,
  output logic run_o,
  output logic sample_o,
  output logic bit_end_o,
  output logic last_o,
  output logic sclk_o
);
  localparam int CW = $clog2(SLOW_P);
  localparam int BW = $clog2(BITS);
  localparam logic [CW-1:0] S_END  = CW'(SLOW_P - 1);
  localparam logic [CW-1:0] F_END  = CW'(FAST_P - 1);
  localparam logic [CW-1:0] S_FALL = CW'(SLOW_P / 4);
  localparam logic [CW-1:0] F_FALL = CW'(FAST_P / 4);
  localparam logic [CW-1:0] S_RISE = CW'(SLOW_P / 4 + SLOW_P / 2);
  localparam logic [CW-1:0] F_RISE = CW'(FAST_P / 4 + FAST_P / 2);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  logic [CW-1:0] ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          run_q, run_d;
  logic          fast_q, fast_d;
  logic [CW-1:0] ph_end, ph_fall, ph_rise;

  assign ph_end  = fast_q ? F_END  : S_END;
  assign ph_fall = fast_q ? F_FALL : S_FALL;
  assign ph_rise = fast_q ? F_RISE : S_RISE;

  assign run_o     = run_q;
  assign bit_end_o = run_q && (ph_q == ph_end);
  assign last_o    = bit_end_o && (bit_q == LAST_BIT);
  assign sample_o  = run_q && (ph_q == ph_rise - CW'(1));
  assign sclk_o    = ~(run_q && (ph_q >= ph_fall) && (ph_q < ph_rise));

  always_comb begin
    ph_d   = ph_q;
    bit_d  = bit_q;
    run_d  = run_q;
    fast_d = fast_q;
    if (start_i && !run_q) begin
      run_d  = 1'b1;
      ph_d   = '0;
      bit_d  = '0;
      fast_d = fast_i;
    end else if (bit_end_o) begin
      ph_d = '0;
      if (last_o) run_d = 1'b0;
      else        bit_d = bit_q + BW'(1);
    end else if (run_q) begin
      ph_d = ph_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bit_q  <= '0;
      run_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      run_q  <= run_d;
      fast_q <= fast_d;
    end
  end
endmodule

// File: rtl/sse_shifter.sv
module sse_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [BITS-1:0] load_val_i,
  input  logic            tx_shift_i,
  input  logic            rx_shift_i,
  input  logic            sd_i,
  output logic [BITS-1:0] sr_o
);
  logic [BITS-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)          sr_d = load_val_i;
    else if (tx_shift_i) sr_d = {1'b0, sr_q[BITS-1:1]};
    else if (rx_shift_i) sr_d = {sd_i, sr_q[BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/sse_flags.sv
module sse_flags #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_done_i,
  input  logic            rx_done_i,
  input  logic            clr_tx_i,
  input  logic            clr_rx_i,
  input  logic [BITS-1:0] rx_val_i,
  output logic            txf_o,
  output logic            rxf_o,
  output logic [BITS-1:0] rx_byte_o
);
  logic            txf_q, txf_d, rxf_q, rxf_d;
  logic [BITS-1:0] rxb_q, rxb_d;

  always_comb begin
    txf_d = txf_q;
    rxf_d = rxf_q;
    rxb_d = rxb_q;
    if (tx_done_i)     txf_d = 1'b1;
    else if (clr_tx_i) txf_d = 1'b0;
    if (rx_done_i) begin
      rxf_d = 1'b1;
      rxb_d = rx_val_i;
    end else if (clr_rx_i) begin
      rxf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txf_q <= 1'b0;
      rxf_q <= 1'b0;
      rxb_q <= '0;
    end else begin
      txf_q <= txf_d;
      rxf_q <= rxf_d;
      rxb_q <= rxb_d;
    end
  end

  assign txf_o     = txf_q;
  assign rxf_o     = rxf_q;
  assign rx_byte_o = rxb_q;
endmodule

// File: rtl/sync_shift_engine.sv
module sync_shift_engine
  import sse_pkg::*;
#(
  parameter int BITS   = 8,
  parameter int SLOW_P = 12,
  parameter int FAST_P = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fast_i,
  input  logic            tx_wr_i,
  input  logic [BITS-1:0] tx_byte_i,
  input  logic            rx_en_i,
  input  logic            clr_txf_i,
  input  logic            clr_rxf_i,
  input  logic            sd_i,
  output logic            sd_o,
  output logic            sd_oe,
  output logic            sclk_o,
  output logic            txf_o,
  output logic            rxf_o,
  output logic [BITS-1:0] rx_byte_o
);
  sse_dir_e        dir_q, dir_d;
  logic            run, sample, bit_end, last;
  logic            start_tx, start_rx;
  logic [BITS-1:0] sr;

  assign start_tx = !run && tx_wr_i;
  assign start_rx = !run && !tx_wr_i && rx_en_i && !rxf_o;

  always_comb begin
    dir_d = dir_q;
    if (start_tx)      dir_d = DIR_TX;
    else if (start_rx) dir_d = DIR_RX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= DIR_RX;
    else        dir_q <= dir_d;
  end

  sse_timing #(.BITS(BITS), .SLOW_P(SLOW_P), .FAST_P(FAST_P)) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_tx || start_rx),
    .fast_i    (fast_i),
    .run_o     (run),
    .sample_o  (sample),
    .bit_end_o (bit_end),
    .last_o    (last),
    .sclk_o    (sclk_o)
  );

  sse_shifter #(.BITS(BITS)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_tx),
    .load_val_i (tx_byte_i),
    .tx_shift_i (bit_end && (dir_q == DIR_TX)),
    .rx_shift_i (sample && (dir_q == DIR_RX)),
    .sd_i       (sd_i),
    .sr_o       (sr)
  );

  sse_flags #(.BITS(BITS)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_done_i (last && (dir_q == DIR_TX)),
    .rx_done_i (last && (dir_q == DIR_RX)),
    .clr_tx_i  (clr_txf_i),
    .clr_rx_i  (clr_rxf_i),
    .rx_val_i  (sr),
    .txf_o     (txf_o),
    .rxf_o     (rxf_o),
    .rx_byte_o (rx_byte_o)
  );

  assign sd_oe = run && (dir_q == DIR_TX);
  assign sd_o  = sd_oe && sr[0];
endmodule

// File: rtl/sse_checker.sv
module sse_checker (
  input logic clk,
  input logic rst_n,
  input logic clr_txf_i,
  input logic clr_rxf_i,
  input logic sd_o,
  input logic sd_oe,
  input logic sclk_o,
  input logic txf_o,
  input logic rxf_o
);
  // R8: flags are sticky until cleared
  p_txf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txf_o && !clr_txf_i |=> txf_o);
  p_rxf_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxf_o) |-> $past(clr_rxf_i));
  // R6: a full receive flag keeps the clock parked high
  p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_o && !sd_oe |=> sclk_o);
  // R3: data holds while the clock is low
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_o && !$past(sclk_o) |-> $stable(sd_o));
  // R4: transmit flag rises as the pin is released
  p_txf_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txf_o) |-> $past(sd_oe) && !sd_oe);
  // R9: receive completion never drives the pin
  p_rx_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxf_o) |-> !sd_oe);
endmodule

bind sync_shift_engine sse_checker u_sse_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_txf_i (clr_txf_i),
  .clr_rxf_i (clr_rxf_i),
  .sd_o      (sd_o),
  .sd_oe     (sd_oe),
  .sclk_o    (sclk_o),
  .txf_o     (txf_o),
  .rxf_o     (rxf_o)
);

// File: tb/sync_shift_engine_bench.sv
module sync_shift_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_i = 1'b0, tx_wr_i = 1'b0, rx_en_i = 1'b0;
  logic clr_txf_i = 1'b0, clr_rxf_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic sd_i, sd_o, sd_oe, sclk_o, txf_o, rxf_o;
  logic [7:0] rx_byte_o;

  int checks = 0, fails = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic       cur_fast = 1'b0;
  logic [7:0] dev_byte = 8'h00;
  logic [2:0] dev_i = 3'd0;
  logic p_sclk = 1'b1, p_oe = 1'b0, p_sd = 1'b0, p_rxf = 1'b0;
  int lead_cnt = 0, low_cnt = 0, nbits = 0, cyc = 0;
  logic [7:0] got = 8'h00;

  assign sd_i = dev_byte[dev_i];

  always #10 clk = ~clk;

  sync_shift_engine u_sync_shift_engine (
    .clk(clk), .rst_n(rst_n), .fast_i(fast_i), .tx_wr_i(tx_wr_i),
    .tx_byte_i(tx_byte_i), .rx_en_i(rx_en_i), .clr_txf_i(clr_txf_i),
    .clr_rxf_i(clr_rxf_i), .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe),
    .sclk_o(sclk_o), .txf_o(txf_o), .rxf_o(rxf_o), .rx_byte_o(rx_byte_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: external device model and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (sd_oe && !p_oe) begin lead_cnt = 0; nbits = 0; end
      if (p_sclk && !sclk_o && sd_oe && nbits == 0)
        chk(lead_cnt == (cur_fast ? 1 : 3), "R3 lead", lead_cnt, cur_fast ? 1 : 3);
      if (!sclk_o) low_cnt++;
      if (!p_sclk && sclk_o) begin
        chk(low_cnt == (cur_fast ? 2 : 6), "R3 low width", low_cnt, cur_fast ? 2 : 6);
        low_cnt = 0;
        if (p_oe) begin
          got[nbits] = p_sd;
          nbits++;
          if (nbits == 8) begin
            if (tx_q.size() == 0) chk(1'b0, "R7 unexpected frame", got, 0);
            else begin
              logic [7:0] e;
              e = tx_q.pop_front();
              chk(got == e, "R2 tx byte", got, e);
            end
            nbits = 0;
          end
        end else begin
          dev_i = dev_i + 3'd1;
        end
      end
      if (rxf_o && !p_rxf) begin
        if (rx_q.size() == 0) chk(1'b0, "R6 unexpected rx", rx_byte_o, 0);
        else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          chk(rx_byte_o == e, "R5 rx byte", rx_byte_o, e);
        end
      end
      if (sd_oe) lead_cnt++;
      p_sclk = sclk_o; p_oe = sd_oe; p_sd = sd_o; p_rxf = rxf_o;
    end
  end

  task automatic do_tx(input logic [7:0] b, input logic f, input bit extra, input bit clash);
    int per, n;
    per = f ? 4 : 12;
    cur_fast = f;
    tx_q.push_back(b);
    @(negedge clk); fast_i = f; tx_byte_i = b; tx_wr_i = 1'b1;
    @(negedge clk); tx_wr_i = 1'b0; n = 1;
    while (!txf_o && n < 400) begin
      tx_wr_i   = (extra && n == 12);
      tx_byte_i = extra ? ~b : b;
      clr_txf_i = (clash && n == 8 * per);
      @(negedge clk); n++;
    end
    tx_wr_i = 1'b0; clr_txf_i = 1'b0;
    chk(n == 8 * per + 1, "R4 tx done cycles", n, 8 * per + 1);
    chk(!sd_oe, "R4 oe released", sd_oe, 0);
  endtask

  task automatic clear_tx();
    @(negedge clk); clr_txf_i = 1'b1;
    @(negedge clk); clr_txf_i = 1'b0;
    chk(!txf_o, "R8 txf cleared", txf_o, 0);
  endtask

  task automatic do_rx(input logic [7:0] b, input logic f);
    int n;
    bit drove;
    drove = 1'b0;
    dev_byte = b; cur_fast = f;
    rx_q.push_back(b);
    @(negedge clk); fast_i = f; rx_en_i = 1'b1; n = 0;
    while (!rxf_o && n < 400) begin
      @(negedge clk); n++;
      if (sd_oe) drove = 1'b1;
    end
    rx_en_i = 1'b0;
    chk(rxf_o, "R5 rxf set", rxf_o, 1);
    chk(rx_byte_o == b, "R5 rx value", rx_byte_o, b);
    chk(!drove, "R9 no drive while receiving", drove, 0);
  endtask

  task automatic watch_idle(input int n, input string req);
    bit moved;
    moved = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!sclk_o || sd_oe) moved = 1'b1;
    end
    chk(!moved, req, moved, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_o && !sd_oe, "R1 pins idle", {sclk_o, sd_oe}, 2);
    chk(!txf_o && !rxf_o, "R1 flags", {txf_o, rxf_o}, 0);
    chk(rx_byte_o == 8'h00, "R1 rx byte", rx_byte_o, 0);
    rst_n = 1'b1;
    watch_idle(5, "R9 idle released");

    do_tx(8'hA5, 1'b0, 1'b0, 1'b0);
    clear_tx();
    do_tx(8'h3C, 1'b1, 1'b0, 1'b1);
    chk(txf_o, "R8 set beats clear", txf_o, 1);
    clear_tx();
    do_tx(8'h81, 1'b1, 1'b1, 1'b0);
    watch_idle(30, "R7 write while busy ignored");
    clear_tx();

    do_rx(8'h5A, 1'b0);
    rx_en_i = 1'b1; dev_byte = 8'hFF;
    watch_idle(50, "R6 rxf blocks reception");
    chk(rx_byte_o == 8'h5A, "R6 rx byte held", rx_byte_o, 8'h5A);
    rx_en_i = 1'b0;
    @(negedge clk); clr_rxf_i = 1'b1;
    @(negedge clk); clr_rxf_i = 1'b0;
    chk(!rxf_o, "R8 rxf cleared", rxf_o, 0);
    watch_idle(40, "R6 disabled receive");
    do_rx(8'hC3, 1'b1);
    @(negedge clk); clr_rxf_i = 1'b1;
    @(negedge clk); clr_rxf_i = 1'b0;

    cur_fast = 1'b1;
    tx_q.push_back(8'hE7);
    @(negedge clk); fast_i = 1'b1; tx_byte_i = 8'hE7; tx_wr_i = 1'b1; rx_en_i = 1'b1;
    @(negedge clk); tx_wr_i = 1'b0; rx_en_i = 1'b0;
    chk(sd_oe, "R7 write wins over receive", sd_oe, 1);
    for (int i = 0; i < 60 && !txf_o; i++) @(negedge clk);
    chk(txf_o, "R7 tx completed", txf_o, 1);
    chk(!rxf_o, "R7 no reception", rxf_o, 0);
    repeat (4) @(negedge clk);
    chk(tx_q.size() == 0 && rx_q.size() == 0, "R2 scoreboard drained",
        tx_q.size() + rx_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule